// File: doc/BRIEF.md
# Debug Monitor Return Sequencer

This block carries out the return from a debug monitor for a small processor core. It holds eight 32-bit architectural registers: the program counter, an interrupt control word, a context link word, a status word, a stack pointer, a return address, a debug context pointer and a trigger control word. The core loads any of them through a plain write port while the block is idle. A one-cycle `start` pulse begins a return.

On the first clock edge after `start`, the program counter takes the old return address with bit 0 cleared. On the same edge the interrupt control word takes its enable bit and priority field from the context link word as it stood before the return. The block then fetches four words, one at a time, starting at the debug context pointer. They refill the context link, status, stack pointer and return address registers, in that order. `done` marks the end of the sequence. If the feature input is high at that point, the trigger control word is also cleared.

Read requests use a valid/ready handshake:
- `mem_req` is the valid and `mem_ready` is the ready.
- A request stays up with a stable `mem_addr` until the memory raises `mem_ready`.
- The read data must be on `mem_rdata` in the same cycle as `mem_ready`.
- The memory applies back-pressure by holding `mem_ready` low for any number of cycles.
- Only one read is ever outstanding.

Top module: `mon_return_seq`

## Requirements
- R1: After reset all eight registers read zero, and `busy`, `done` and `mem_req` are low.
- R2: While idle, `wr_en` loads `wr_data` into the register chosen by `wr_sel`. The codes are 0 pc, 1 interrupt control, 2 context link, 3 status, 4 stack pointer, 5 return address, 6 debug pointer, 7 trigger control. While `busy`, `wr_en` is ignored and the debug pointer keeps its value.
- R3: One cycle after `start` is accepted, `pc_o` equals the pre-return return address with bit 0 forced to 0.
- R4: In that same cycle, interrupt control bit 8 equals context link bit 23, and interrupt control bits 7:0 equal context link bits 31:24, both taken from the pre-return link. Interrupt control bits 31:9 keep their values.
- R5: The four reads go to the debug pointer plus 0, 4, 8 and 12, with wraparound modulo 2^ADDR_W. While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` is unchanged.
- R6: The four words read are stored into the context link, status, stack pointer and return address registers, in that order. The pc keeps the value written in R3.
- R7: `mem_req` first rises in the same cycle that the R3/R4 updates become visible, and it is low whenever `busy` is low.
- R8: `done` is high for exactly one cycle, namely the cycle after the fourth read is accepted. In that cycle `busy` is already low and all four restored registers hold their new values.
- R9: If `feat_en` is high on the edge that accepts the fourth read, the trigger control word is 0 when `done` is high. Otherwise the trigger control word is unchanged.
- R10: A `start` pulse while `busy` is ignored. Once `done` has passed, no further reads are issued and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a return sequence |
| feat_en | input | 1 | Clear trigger control at completion |
| wr_en | input | 1 | Register write strobe (idle only) |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Register write data |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | ADDR_W | Read byte address |
| mem_ready | input | 1 | Read accepted, data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_o | output | 32 | Program counter |
| ictl_o | output | 32 | Interrupt control word |
| link_o | output | 32 | Context link word |
| stat_o | output | 32 | Status word |
| sp_o | output | 32 | Stack pointer |
| ra_o | output | 32 | Return address |
| dptr_o | output | 32 | Debug context pointer |
| trig_o | output | 32 | Trigger control word |

## Verification
The bench builds the block with ADDR_W set to 8. This lets debug pointers near the top of the byte range push the four-word window across the address wrap, so the modular address step becomes visible. The bench sweeps 48 operations, each with:
- a different context link value, so both states of the enable bit and many priority values occur;
- return addresses of both parities;
- both settings of `feat_en`;
- a per-read stall of 0 to 3 cycles.

Stray `start` and `wr_en` strobes are injected mid-sequence to exercise the ignore rules.

// File: rtl/mon_ret_pkg.sv
package mon_ret_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 4;
  localparam int PRIO_W     = 8;
  localparam int LINK_PRIO_LSB = 24;
  localparam int LINK_IE_BIT   = 23;
  localparam int ICTL_IE_BIT   = 8;
  localparam int BYTES_PER_WORD = WORD_W / 8;

  typedef enum logic [2:0] {
    SEL_PC   = 3'd0,
    SEL_ICTL = 3'd1,
    SEL_LINK = 3'd2,
    SEL_STAT = 3'd3,
    SEL_SP   = 3'd4,
    SEL_RA   = 3'd5,
    SEL_DPTR = 3'd6,
    SEL_TRIG = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [WORD_W-1:0] pc;
    logic [WORD_W-1:0] ictl;
    logic [WORD_W-1:0] link;
    logic [WORD_W-1:0] stat;
    logic [WORD_W-1:0] sp;
    logic [WORD_W-1:0] ra;
    logic [WORD_W-1:0] dptr;
    logic [WORD_W-1:0] trig;
  } arch_t;
endpackage

// File: rtl/mon_ret_ctrl.sv
module mon_ret_ctrl #(
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mem_ready,
  output logic             busy,
  output logic             accept,
  output logic             ld_en,
  output logic [IDX_W-1:0] ld_idx,
  output logic             finish,
  output logic             done
);
  typedef enum logic {ST_IDLE, ST_FETCH} state_e;
  state_e state_q;
  logic [IDX_W-1:0] idx_q;

  assign busy   = (state_q == ST_FETCH);
  assign accept = start && (state_q == ST_IDLE);
  assign ld_en  = busy && mem_ready;
  assign ld_idx = idx_q;
  assign finish = ld_en && (idx_q == IDX_W'(NUM_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        state_q <= ST_FETCH;
        idx_q   <= '0;
      end else if (ld_en) begin
        if (finish) begin
          state_q <= ST_IDLE;
          idx_q   <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ready) |=> (busy && $stable(idx_q))); // R5
endmodule

// File: rtl/mon_ret_rd.sv
module mon_ret_rd
  import mon_ret_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int STEP_SH = $clog2(BYTES_PER_WORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] base,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr
);
  logic [ADDR_W-1:0] offset;

  assign offset   = ADDR_W'(idx) << STEP_SH;
  assign mem_req  = busy;
  assign mem_addr = base[ADDR_W-1:0] + offset;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R5
endmodule

// File: rtl/mon_ret_arch.sv
module mon_ret_arch
  import mon_ret_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              accept,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              finish,
  input  logic              feat_en,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output arch_t             regs
);
  arch_t r_q;
  logic  wr_ok;

  assign wr_ok = wr_en && !busy && !accept;
  assign regs  = r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_sel)
          SEL_PC:   r_q.pc   <= wr_data;
          SEL_ICTL: r_q.ictl <= wr_data;
          SEL_LINK: r_q.link <= wr_data;
          SEL_STAT: r_q.stat <= wr_data;
          SEL_SP:   r_q.sp   <= wr_data;
          SEL_RA:   r_q.ra   <= wr_data;
          SEL_DPTR: r_q.dptr <= wr_data;
          SEL_TRIG: r_q.trig <= wr_data;
          default:  ;
        endcase
      end
      if (accept) begin
        r_q.pc <= {r_q.ra[WORD_W-1:1], 1'b0};
        r_q.ictl[ICTL_IE_BIT] <= r_q.link[LINK_IE_BIT];
        r_q.ictl[PRIO_W-1:0]  <= r_q.link[LINK_PRIO_LSB +: PRIO_W];
      end
      if (ld_en) begin
        case (ld_idx)
          IDX_W'(0): r_q.link <= ld_data;
          IDX_W'(1): r_q.stat <= ld_data;
          IDX_W'(2): r_q.sp   <= ld_data;
          IDX_W'(3): r_q.ra   <= ld_data;
          default:   ;
        endcase
      end
      if (finish && feat_en) begin
        r_q.trig <= '0;
      end
    end
  end

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (r_q.pc[0] == 1'b0)); // R3
  AST_TRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && feat_en) |=> (r_q.trig == '0)); // R9
  AST_DPTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(r_q.dptr)); // R2
  AST_ICTL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(r_q.ictl)); // R4
endmodule

// File: rtl/mon_return_seq.sv
module mon_return_seq
  import mon_ret_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              feat_en,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [31:0]       wr_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       pc_o,
  output logic [31:0]       ictl_o,
  output logic [31:0]       link_o,
  output logic [31:0]       stat_o,
  output logic [31:0]       sp_o,
  output logic [31:0]       ra_o,
  output logic [31:0]       dptr_o,
  output logic [31:0]       trig_o
);
  localparam int IDX_W = $clog2(NUM_WORDS);

  logic             accept, ld_en, finish;
  logic [IDX_W-1:0] ld_idx;
  arch_t            regs;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(wr_sel);

  mon_ret_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_ready(mem_ready),
    .busy(busy), .accept(accept), .ld_en(ld_en), .ld_idx(ld_idx),
    .finish(finish), .done(done)
  );

  mon_ret_rd #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .busy(busy), .idx(ld_idx), .base(regs.dptr),
    .mem_ready(mem_ready), .mem_req(mem_req), .mem_addr(mem_addr)
  );

  mon_ret_arch #(.NUM_WORDS(NUM_WORDS)) u_arch (
    .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept), .ld_en(ld_en),
    .ld_idx(ld_idx), .ld_data(mem_rdata), .finish(finish), .feat_en(feat_en),
    .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data), .regs(regs)
  );

  assign pc_o   = regs.pc;
  assign ictl_o = regs.ictl;
  assign link_o = regs.link;
  assign stat_o = regs.stat;
  assign sp_o   = regs.sp;
  assign ra_o   = regs.ra;
  assign dptr_o = regs.dptr;
  assign trig_o = regs.trig;

  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_req && busy)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R7
endmodule

// File: tb/sim_mon_return_seq.sv
module sim_mon_return_seq;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, feat_en = 1'b0, wr_en = 1'b0, mem_ready = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0, mem_rdata = '0;
  logic mem_req, busy, done;
  logic [AW-1:0] mem_addr;
  logic [31:0] pc_o, ictl_o, link_o, stat_o, sp_o, ra_o, dptr_o, trig_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mon_return_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .feat_en(feat_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .pc_o(pc_o), .ictl_o(ictl_o), .link_o(link_o), .stat_o(stat_o),
    .sp_o(sp_o), .ra_o(ra_o), .dptr_o(dptr_o), .trig_o(trig_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mdat(input logic [AW-1:0] a, input int t);
    return ((32'(a) + 32'd1) * 32'h9E3779B1) ^ (32'(t) << 16);
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc_o, 0);   chk("R1 ictl", ictl_o, 0);
    chk("R1 link", link_o, 0); chk("R1 trig", trig_o, 0);
    chk("R1 flags", {29'd0, busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 48; t++) begin
      logic [31:0] link, ra, ictl, trig, dptr, pc_exp, ictl_exp, trig_exp;
      logic feat;
      link = (32'h01234567 * 32'(t + 3)) ^ (32'(t) << 23);
      ra   = 32'h80001001 + 32'(t);
      ictl = ~link ^ 32'h00A5_5A5A;
      trig = 32'hF00D0000 | 32'(t);
      dptr = 32'h12340000 + 32'(t * 12 + 236);
      feat = t[0] ^ t[2];
      wr(3'd0, 32'hCAFE0000 + 32'(t));
      wr(3'd1, ictl); wr(3'd2, link); wr(3'd3, 32'h1111 * 32'(t));
      wr(3'd4, 32'h2222); wr(3'd5, ra); wr(3'd6, dptr); wr(3'd7, trig);
      chk("R2 dptr write", dptr_o, dptr);
      chk("R2 trig write", trig_o, trig);

      pc_exp   = {ra[31:1], 1'b0};
      ictl_exp = {ictl[31:9], link[23], link[31:24]};
      trig_exp = feat ? 32'd0 : trig;

      feat_en = feat;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R3 pc", pc_o, pc_exp);
      chk("R4 ictl", ictl_o, ictl_exp);
      chk("R7 req with commit", {30'd0, mem_req, busy}, 32'd3);

      for (int k = 0; k < 4; k++) begin
        int s;
        logic [AW-1:0] ea;
        s  = (t + k) % 4;
        ea = AW'(dptr[AW-1:0] + AW'(4 * k));
        for (int w = 0; w < s; w++) begin
          chk("R5 stall addr", {23'd0, mem_req, mem_addr}, {23'd0, 1'b1, ea});
          @(negedge clk);
        end
        chk("R5 addr", {23'd0, mem_req, mem_addr}, {23'd0, 1'b1, ea});
        chk("R8 no early done", {31'd0, done}, 0);
        mem_ready = 1'b1;
        mem_rdata = mdat(ea, t);
        if (k == 1) start = 1'b1;
        if (k == 2) begin
          wr_en = 1'b1; wr_sel = 3'd6; wr_data = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        mem_ready = 1'b0; start = 1'b0; wr_en = 1'b0;
      end

      chk("R8 done", {30'd0, done, busy}, 32'd2);
      chk("R6 link", link_o, mdat(AW'(dptr[AW-1:0]), t));
      chk("R6 stat", stat_o, mdat(AW'(dptr[AW-1:0] + 8'd4), t));
      chk("R6 sp", sp_o, mdat(AW'(dptr[AW-1:0] + 8'd8), t));
      chk("R6 ra", ra_o, mdat(AW'(dptr[AW-1:0] + 8'd12), t));
      chk("R6 pc kept", pc_o, pc_exp);
      chk("R9 trig", trig_o, trig_exp);
      chk("R2 dptr ignored", dptr_o, dptr);
      @(negedge clk);
      chk("R8 done one cycle", {31'd0, done}, 0);
      chk("R10 no restart", {30'd0, busy, mem_req}, 0);
      chk("R4 ictl held", ictl_o, ictl_exp);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule